// File: doc/BRIEF.md
# Asynchronous Strobe-Paced Register Bus Slave

This block lets an external processor reach an internal register space over an asynchronous, strobe-paced host bus. The host bus has a 15-bit address, an 8-bit bidirectional data bus, an active-low chip select from outside address decoding, an address strobe, a read/write select and a data strobe. The block answers on an active-low data-acknowledge output. Every host input is brought into the local clock domain through a two-flop synchroniser, and strobe edges are found on the synchronised copies.

The address is captured when the address strobe returns high. A falling data strobe then starts the data phase. For a read, the block issues a single read pulse to the internal register port and turns on its data drivers. It waits for the port's ready, which may take any number of cycles. It then loads the returned byte onto the bus and only after that lowers the acknowledge. For a write, the block samples the host's data, issues a single write pulse, and acknowledges once the port reports completion. The host ends every cycle by raising the data strobe. The block then lifts the acknowledge and floats the bus.

Top module: `async_reg_bus_slave`

## Requirements
- R1: After reset the acknowledge output is high, the data bus is not driven, and neither the read pulse nor the write pulse is asserted.
- R2: The address is taken from the address pins on the synchronised low-to-high transition of the address strobe while chip select is low, and it is presented on `reg_addr`. Later changes on the address pins do not alter the access in progress.
- R3: With the read/write select high (1 = read), a falling data strobe under chip select produces exactly one single-cycle `reg_rd` pulse. The data bus stays undriven until the data strobe has fallen.
- R4: After the data strobe falls, the acknowledge stays high for at least the two synchroniser cycles and until the internal port asserts `reg_ready`. The acknowledge falls in the cycle after ready is seen, and the read byte is already on the data bus when it does. This holds for any port latency.
- R5: With the read/write select low (0 = write), a falling data strobe under chip select samples the data bus and produces exactly one `reg_wr` pulse carrying that byte on `reg_wdata`. The acknowledge falls after `reg_ready`. The block never drives the data bus during a write.
- R6: Once the synchronised data strobe is high, the acknowledge returns high and the data drivers turn off on the next clock edge, which is at most three clock edges after the pin rises. The block is then ready for the next access.
- R7: While chip select is high, address strobe and data strobe activity is ignored. No pulse is issued, the acknowledge stays high, the data bus stays undriven and `reg_addr` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Host chip select, active low |
| bus_as_n | input | 1 | Host address strobe, address captured on its rise |
| bus_rw | input | 1 | Host read/write select, 1 = read, 0 = write |
| bus_ds_n | input | 1 | Host data strobe, active low |
| bus_addr | input | 15 | Host address |
| bus_data | inout | 8 | Bidirectional host data |
| bus_ack_n | output | 1 | Data acknowledge, active low |
| reg_addr | output | 15 | Latched address to internal port |
| reg_wdata | output | 8 | Write data to internal port |
| reg_wr | output | 1 | Single-cycle write request |
| reg_rd | output | 1 | Single-cycle read request |
| reg_rdata | input | 8 | Read data from internal port |
| reg_ready | input | 1 | Internal port completion |

## Verification
Reads run at internal latencies of zero, three and nine cycles. This shows that the acknowledge follows the port's ready and not a fixed delay, and that the byte is valid whenever the acknowledge is seen low. Writes are followed by reads of the same locations, which separates a correct write pulse from a missing or duplicated one. One access moves the address pins after the strobe has risen, to tell capture on the strobe edge apart from a transparent address path. Strobes with chip select high, for both directions, show whether deselected activity leaks into pulses, the acknowledge, the bus or the latched address.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int unsigned ARB_ADDR_W = 15;
    localparam int unsigned ARB_DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_WAIT = 2'd1,
        ST_WR_WAIT = 2'd2,
        ST_ACK     = 2'd3
    } arb_state_e;
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
    parameter int unsigned    W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d.s1 = d_i;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.s1 <= RST_VAL;
            r_q.s2 <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign q_o = r_q.s2;
endmodule

// File: rtl/arb_addr_latch.sv
module arb_addr_latch #(
    parameter int unsigned AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          as_s,
    input  logic          cs_s,
    input  logic [AW-1:0] addr_s,
    output logic [AW-1:0] addr_o
);
    typedef struct packed {
        logic          as_prev;
        logic [AW-1:0] addr;
    } lat_t;

    lat_t l_d, l_q;
    logic as_rise;

    always_comb begin
        as_rise   = !l_q.as_prev && as_s;
        l_d       = l_q;
        l_d.as_prev = as_s;
        if (as_rise && !cs_s) begin
            l_d.addr = addr_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q.as_prev <= 1'b1;
            l_q.addr    <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign addr_o = l_q.addr;

    // R2 / R7: address moves only on a selected strobe rise
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(as_rise && !cs_s) |=> $stable(addr_o));
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          ds_s,
    input  logic          rw_s,
    input  logic [DW-1:0] data_s,
    input  logic          reg_ready,
    input  logic [DW-1:0] reg_rdata,
    output logic          reg_rd,
    output logic          reg_wr,
    output logic [DW-1:0] reg_wdata,
    output logic          drive_en,
    output logic [DW-1:0] drive_data,
    output logic          ack_n
);
    import arb_pkg::*;

    typedef struct packed {
        arb_state_e    state;
        logic          ds_prev;
        logic          oe;
        logic          ack_n;
        logic          rd;
        logic          wr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  ds_fall;

    always_comb begin
        ds_fall    = c_q.ds_prev && !ds_s;
        c_d        = c_q;
        c_d.ds_prev = ds_s;
        c_d.rd     = 1'b0;
        c_d.wr     = 1'b0;
        unique case (c_q.state)
            ST_IDLE: begin
                c_d.oe    = 1'b0;
                c_d.ack_n = 1'b1;
                if (ds_fall && !cs_s) begin
                    if (rw_s) begin
                        c_d.rd    = 1'b1;
                        c_d.oe    = 1'b1;
                        c_d.state = ST_RD_WAIT;
                    end else begin
                        c_d.wdata = data_s;
                        c_d.wr    = 1'b1;
                        c_d.state = ST_WR_WAIT;
                    end
                end
            end
            ST_RD_WAIT: begin
                if (ds_s) begin
                    c_d.oe    = 1'b0;
                    c_d.state = ST_IDLE;
                end else if (reg_ready) begin
                    c_d.rdata = reg_rdata;
                    c_d.ack_n = 1'b0;
                    c_d.state = ST_ACK;
                end
            end
            ST_WR_WAIT: begin
                if (ds_s) begin
                    c_d.state = ST_IDLE;
                end else if (reg_ready) begin
                    c_d.ack_n = 1'b0;
                    c_d.state = ST_ACK;
                end
            end
            ST_ACK: begin
                if (ds_s) begin
                    c_d.ack_n = 1'b1;
                    c_d.oe    = 1'b0;
                    c_d.state = ST_IDLE;
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state   <= ST_IDLE;
            c_q.ds_prev <= 1'b1;
            c_q.oe      <= 1'b0;
            c_q.ack_n   <= 1'b1;
            c_q.rd      <= 1'b0;
            c_q.wr      <= 1'b0;
            c_q.wdata   <= '0;
            c_q.rdata   <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign reg_rd     = c_q.rd;
    assign reg_wr     = c_q.wr;
    assign reg_wdata  = c_q.wdata;
    assign drive_en   = c_q.oe;
    assign drive_data = c_q.rdata;
    assign ack_n      = c_q.ack_n;

    p_rd_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);
    p_ack_after_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> $past(reg_ready));
    p_write_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> !drive_en);
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && ds_s) |=> (ack_n && !drive_en));
    p_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_IDLE && cs_s) |=> (!reg_rd && !reg_wr));
endmodule

// File: rtl/async_reg_bus_slave.sv
module async_reg_bus_slave #(
    parameter int unsigned ADDR_W = arb_pkg::ARB_ADDR_W,
    parameter int unsigned DATA_W = arb_pkg::ARB_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_as_n,
    input  logic              bus_rw,
    input  logic              bus_ds_n,
    input  logic [ADDR_W-1:0] bus_addr,
    inout  wire  [DATA_W-1:0] bus_data,
    output logic              bus_ack_n,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_ready
);
    localparam int unsigned CTL_W = 4;

    logic [CTL_W-1:0]  ctl_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic              cs_s, as_s, rw_s, ds_s;
    logic              drive_en;
    logic [DATA_W-1:0] drive_data;

    arb_sync #(.W(CTL_W), .RST_VAL(4'b1111)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n),
        .d_i({bus_cs_n, bus_as_n, bus_rw, bus_ds_n}),
        .q_o(ctl_s)
    );
    assign {cs_s, as_s, rw_s, ds_s} = ctl_s;

    arb_sync #(.W(ADDR_W), .RST_VAL('0)) u_sync_addr (
        .clk(clk), .rst_n(rst_n), .d_i(bus_addr), .q_o(addr_s)
    );

    arb_sync #(.W(DATA_W), .RST_VAL('0)) u_sync_data (
        .clk(clk), .rst_n(rst_n), .d_i(bus_data), .q_o(data_s)
    );

    arb_addr_latch #(.AW(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .as_s(as_s), .cs_s(cs_s), .addr_s(addr_s),
        .addr_o(reg_addr)
    );

    arb_ctrl #(.DW(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cs_s(cs_s), .ds_s(ds_s), .rw_s(rw_s), .data_s(data_s),
        .reg_ready(reg_ready), .reg_rdata(reg_rdata),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .drive_en(drive_en), .drive_data(drive_data),
        .ack_n(bus_ack_n)
    );

    assign bus_data = drive_en ? drive_data : {DATA_W{1'bz}};
endmodule

// File: tb/tb_async_reg_bus_slave.sv
`timescale 1ns/1ps
module tb_async_reg_bus_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, as_n = 1'b1, rw = 1'b1, ds_n = 1'b1;
    logic [14:0] addr = '0;
    logic        host_oe = 1'b0;
    logic [7:0]  host_d = '0;
    tri   [7:0]  bus_data;
    logic        ack_n;
    logic [14:0] reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic        reg_wr, reg_rd, reg_ready;

    int checks = 0, errors = 0, cycles = 0;
    int rd_cnt = 0, wr_cnt = 0;
    int lat = 0;
    logic [7:0] mem [0:255];
    logic       busy;
    int         cnt;

    always #4 clk = ~clk;

    assign bus_data = host_oe ? host_d : 8'hzz;

    async_reg_bus_slave dut (
        .clk(clk), .rst_n(rst_n),
        .bus_cs_n(cs_n), .bus_as_n(as_n), .bus_rw(rw), .bus_ds_n(ds_n),
        .bus_addr(addr), .bus_data(bus_data), .bus_ack_n(ack_n),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .reg_ready(reg_ready)
    );

    // internal register file model with programmable latency
    always @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= 0;
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
        end else if (reg_rd || reg_wr) begin
            busy <= 1'b1;
            cnt  <= lat;
            if (reg_wr) mem[reg_addr[7:0]] <= reg_wdata;
        end else if (busy) begin
            if (cnt == 0) busy <= 1'b0;
            else          cnt  <= cnt - 1;
        end
    end
    assign reg_ready = busy && (cnt == 0);
    assign reg_rdata = mem[reg_addr[7:0]];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (reg_rd) rd_cnt <= rd_cnt + 1;
        if (reg_wr) wr_cnt <= wr_cnt + 1;
    end

    always @(posedge clk) begin
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: got %0d cycles expected below 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic t_reset_r1();
        check(ack_n === 1'b1, "R1", "ack after reset", 32'(ack_n), 1);
        check(reg_rd === 1'b0 && reg_wr === 1'b0, "R1", "pulses after reset",
              {30'd0, reg_rd, reg_wr}, 0);
        host_oe = 1'b1; host_d = 8'h00; #1;
        check(bus_data === 8'h00, "R1", "bus undriven after reset", 32'(bus_data), 0);
        host_oe = 1'b0;
    endtask

    task automatic t_read(input logic [14:0] a, input logic [14:0] late_a,
                          input int l, input logic [7:0] exp);
        int n;
        int rd0;
        lat = l;
        rd0 = rd_cnt;
        @(negedge clk);
        cs_n = 1'b0; addr = a; as_n = 1'b0; rw = 1'b1;
        host_oe = 1'b1; host_d = 8'h00;
        repeat (2) @(negedge clk);
        as_n = 1'b1;
        repeat (4) @(negedge clk);
        addr = late_a;
        #1;
        check(bus_data === 8'h00, "R3", "bus undriven before DS falls", 32'(bus_data), 0);
        host_oe = 1'b0;
        @(negedge clk);
        ds_n = 1'b0;
        repeat (2) @(negedge clk);
        check(ack_n === 1'b1, "R4", "ack high right after DS falls", 32'(ack_n), 1);
        n = 0;
        while (ack_n !== 1'b0 && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(ack_n === 1'b0, "R4", "ack asserted for read", 32'(ack_n), 0);
        check(bus_data === exp, "R4", "read byte valid at ack", 32'(bus_data), 32'(exp));
        check(rd_cnt == rd0 + 1, "R3", "one read pulse", rd_cnt, rd0 + 1);
        check(reg_addr === a, "R2", "latched address", 32'(reg_addr), 32'(a));
        ds_n = 1'b1;
        repeat (3) @(negedge clk);
        check(ack_n === 1'b1, "R6", "ack released after DS rise", 32'(ack_n), 1);
        host_oe = 1'b1; host_d = 8'h00; #1;
        check(bus_data === 8'h00, "R6", "bus released after DS rise", 32'(bus_data), 0);
        host_oe = 1'b0;
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic t_write_r5(input logic [14:0] a, input int l, input logic [7:0] wd);
        int n;
        int wr0;
        lat = l;
        wr0 = wr_cnt;
        @(negedge clk);
        cs_n = 1'b0; addr = a; as_n = 1'b0; rw = 1'b0;
        host_oe = 1'b1; host_d = wd;
        repeat (2) @(negedge clk);
        as_n = 1'b1;
        repeat (4) @(negedge clk);
        ds_n = 1'b0;
        n = 0;
        while (ack_n !== 1'b0 && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(ack_n === 1'b0, "R5", "ack asserted for write", 32'(ack_n), 0);
        check(bus_data === wd, "R5", "bus not driven by block in write", 32'(bus_data), 32'(wd));
        check(wr_cnt == wr0 + 1, "R5", "one write pulse", wr_cnt, wr0 + 1);
        check(reg_wdata === wd, "R5", "write data", 32'(reg_wdata), 32'(wd));
        ds_n = 1'b1;
        repeat (3) @(negedge clk);
        check(ack_n === 1'b1, "R6", "ack released after write", 32'(ack_n), 1);
        host_oe = 1'b0; rw = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic t_deselect_r7(input logic dir);
        int rd0;
        int wr0;
        logic [14:0] a0;
        bit ack_seen;
        rd0 = rd_cnt; wr0 = wr_cnt; a0 = reg_addr; ack_seen = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; addr = 15'h7F0F; rw = dir; as_n = 1'b0;
        host_oe = 1'b0;
        repeat (2) @(negedge clk);
        as_n = 1'b1;
        repeat (3) @(negedge clk);
        ds_n = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (ack_n !== 1'b1) ack_seen = 1'b1;
        end
        check(!ack_seen, "R7", "no ack while deselected", 32'(ack_seen), 0);
        check(rd_cnt == rd0 && wr_cnt == wr0, "R7", "no pulses while deselected",
              rd_cnt + wr_cnt, rd0 + wr0);
        check(reg_addr === a0, "R7", "address kept while deselected", 32'(reg_addr), 32'(a0));
        host_oe = 1'b1; host_d = 8'h00; #1;
        check(bus_data === 8'h00, "R7", "bus undriven while deselected", 32'(bus_data), 0);
        host_oe = 1'b0;
        ds_n = 1'b1; rw = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset_r1();
        t_read(15'h1234, 15'h1234, 0, 8'h34 ^ 8'h5A);
        t_read(15'h0011, 15'h0011, 3, 8'h11 ^ 8'h5A);
        t_read(15'h7F80, 15'h7F80, 9, 8'h80 ^ 8'h5A);
        // R2: address pins move after the strobe rise; the strobe-edge value is used
        t_read(15'h00A7, 15'h0033, 1, 8'hA7 ^ 8'h5A);
        t_write_r5(15'h0042, 2, 8'h3C);
        t_read(15'h0042, 15'h0042, 0, 8'h3C);
        t_write_r5(15'h0105, 0, 8'hC3);
        t_read(15'h0105, 15'h0105, 4, 8'hC3);
        t_deselect_r7(1'b1);
        t_deselect_r7(1'b0);
        // R6: a selected access still works after deselected activity
        t_read(15'h0002, 15'h0002, 2, 8'h02 ^ 8'h5A);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule